// File: doc/BRIEF.md
# Quad-channel DAC register update controller

This block keeps the digital state behind a four-channel, 16-bit digital-to-analog converter. A serial front end, which is not part of this block, hands it one complete 32-bit command word at a time together with a one-cycle valid strobe. Each channel has two register stages. The first is a staging (input) register. The second is the output register that drives the converter. The block also reports a 2-bit power mode for each channel.

Several things move codes from the staging stage to the output stage. Commands can do it. An active-low load pin can do it; while that pin is held low it makes writes transparent, and its falling edge copies every channel at once. A per-channel software mask can make a channel behave as if the load pin were tied low. An active-low clear pin forces a programmable code into both stages on its falling edge. A reset-select pin chooses zero scale or midscale as the reset value, and a software reset command restores that same state. Both pins are asynchronous to the system clock. They are synchronised inside the block.

Top module: `dacq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output register takes 0x0000 if `rst_mid` is 0 and 0x8000 if it is 1. Every power mode takes 00 (normal). The clear code takes 00 and the override mask takes 0000.
- R2: Word fields are as follows: command in bits 27:24, channel address in bits 23:20, 16-bit code in bits 19:4. Bits 31:28 and 3:0 are ignored by the write commands. Command 0000 writes the code into the addressed staging register. If the synchronised load pin is low, the same edge also loads the addressed output register.
- R3: While the load pin is high, command 0000 leaves the output register unchanged. A falling edge on `load_n` copies all four staging registers into their output registers at the third rising clock edge after the pin falls.
- R4: Command 0001 copies staging register n into output register n, at any level of the load pin.
- R5: Command 0010 writes staging register n and then loads every output register from its staging register, at any level of the load pin.
- R6: Command 0011 writes staging register n and loads output register n, at any level of the load pin.
- R7: Address values 0 to 3 select channels 0 to 3 and address 1111 selects all channels. Any other address makes commands 0000 to 0011 do nothing.
- R8: Commands 1000 to 1111 change no register.
- R9: Command 0110 loads the override mask from word bits 3:0. A channel whose mask bit is 1 loads its output register on command 0000 even while the load pin is high.
- R10: Command 0101 loads the clear code from word bits 1:0. A falling edge on `clear_n` loads both stages of every channel with 0x0000 (code 00), 0x8000 (01) or 0xFFFF (10). Code 11 changes nothing. The registers change at the third rising edge after the pin falls.
- R11: While the synchronised clear pin is low, load-pin falling edges are ignored. A frame strobed in the same cycle as a clear edge is discarded.
- R12: Command 0100 sets the power mode from word bits 9:8 (00 normal, 01 1 kΩ to ground, 10 100 kΩ to ground, 11 three-state) on every channel whose bit in word bits 3:0 is 1. The address is ignored. Output register contents do not change.
- R13: Command 0111 restores the R1 state, using the present `rst_mid`. This includes the clear code, the override mask and all power modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_mid | input | 1 | Reset value select: 0 zero scale, 1 midscale |
| frame_valid | input | 1 | One-cycle strobe marking a complete command word |
| frame_word | input | 32 | Command word |
| load_n | input | 1 | Asynchronous active-low load pin |
| clear_n | input | 1 | Asynchronous active-low clear pin |
| dac_code | output | 64 | Output registers; channel i in bits 16i+15:16i |
| pwr_mode | output | 8 | Power modes; channel i in bits 2i+1:2i |

## Verification
The hardest case is a clear edge that lands in the same cycle as a frame strobe. That edge only becomes visible to the logic two synchroniser stages after the pin moves. The bench drops `clear_n` and counts two falling clock edges. It then raises the strobe so that the frame and the detected edge meet at one rising edge, and it checks that the frame's code is absent from the output. Staging registers cannot be seen at the ports. The bench reveals them by copying them to the output with command 0001, for example after a clear or while load pulses are being ignored.

// File: rtl/dacq_pkg.sv
// Shared constants for the quad DAC register controller.
// Assumes the 32-bit command word layout fixed by the host framing logic.
package dacq_pkg;
    localparam int unsigned WORD_W = 32;

    // Command opcodes (word bits 27:24)
    localparam logic [3:0] OP_WR_IN   = 4'h0;
    localparam logic [3:0] OP_COPY    = 4'h1;
    localparam logic [3:0] OP_WR_ALL  = 4'h2;
    localparam logic [3:0] OP_WR_UPD  = 4'h3;
    localparam logic [3:0] OP_POWER   = 4'h4;
    localparam logic [3:0] OP_CLRCODE = 4'h5;
    localparam logic [3:0] OP_MASK    = 4'h6;
    localparam logic [3:0] OP_SWRESET = 4'h7;

    localparam logic [3:0] ADDR_ALL = 4'hF;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_1K     = 2'b01,
        PM_100K   = 2'b10,
        PM_HIZ    = 2'b11
    } pmode_e;

    typedef enum logic [1:0] {
        CC_ZERO = 2'b00,
        CC_MID  = 2'b01,
        CC_FULL = 2'b10,
        CC_NONE = 2'b11
    } clr_code_e;
endpackage

// File: rtl/dacq_pin_sync.sv
// Two-flop synchroniser with falling-edge detector for an asynchronous
// active-low pin. The chain keeps sampling while reset is asserted, so a
// pin already low during reset gives no edge afterwards. Assumes reset
// lasts at least three clock cycles.
module dacq_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic fall
);
    logic s1, s2, s3;

    // Synchronise the pin and keep one older sample for edge detection
    always_ff @(posedge clk) begin
        s1 <= pin;
        s2 <= s1;
        s3 <= s2;
    end

    assign level = s2;
    assign fall  = rst_n & s3 & ~s2;
endmodule

// File: rtl/dacq_decode.sv
// Command decoder: turns an accepted command word into per-channel strobes.
// Assumes frame_ok is already qualified (valid, not aborted by a clear).
module dacq_decode
    import dacq_pkg::*;
#(
    parameter int unsigned NCH = 4
) (
    input  logic              frame_ok,
    input  logic [WORD_W-1:0] word,
    input  logic              load_low,
    input  logic [NCH-1:0]    ovr_mask,
    output logic [NCH-1:0]    wr_in,
    output logic [NCH-1:0]    upd,
    output logic [NCH-1:0]    pd_set,
    output logic              clr_ld,
    output logic              mask_ld,
    output logic              sw_rst
);
    logic [3:0]     op;
    logic [3:0]     addr;
    logic [NCH-1:0] sel;
    logic           addr_ok;

    assign op   = word[27:24];
    assign addr = word[23:20];

    // Address select, one bit per channel
    for (genvar i = 0; i < NCH; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_ALL) || (addr == 4'(i));
    end
    assign addr_ok = |sel;

    // Per-channel strobes for data and power commands
    always_comb begin
        wr_in  = '0;
        upd    = '0;
        pd_set = '0;
        if (frame_ok && addr_ok) begin
            case (op)
                OP_WR_IN:  begin
                    wr_in = sel;
                    upd   = sel & (load_low ? {NCH{1'b1}} : ovr_mask);
                end
                OP_COPY:   upd = sel;
                OP_WR_ALL: begin
                    wr_in = sel;
                    upd   = '1;
                end
                OP_WR_UPD: begin
                    wr_in = sel;
                    upd   = sel;
                end
                default: ;
            endcase
        end
        if (frame_ok && op == OP_POWER) pd_set = word[NCH-1:0];
    end

    assign clr_ld  = frame_ok && (op == OP_CLRCODE);
    assign mask_ld = frame_ok && (op == OP_MASK);
    assign sw_rst  = frame_ok && (op == OP_SWRESET);
endmodule

// File: rtl/dacq_channel.sv
// One channel: staging register, output register and power mode.
// Priority: reset > clear > command update > load-pin copy.
module dacq_channel
    import dacq_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_rst,
    input  logic [CW-1:0] rst_val,
    input  logic          clr_hit,
    input  logic [CW-1:0] clr_val,
    input  logic          wr_in,
    input  logic [CW-1:0] wr_data,
    input  logic          upd,
    input  logic          load_copy,
    input  logic          pd_set,
    input  pmode_e        pd_mode,
    output logic [CW-1:0] dac_q,
    output pmode_e        pmode_q
);
    logic [CW-1:0] in_q;

    // Staging register
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) in_q <= rst_val;
        else if (clr_hit)     in_q <= clr_val;
        else if (wr_in)       in_q <= wr_data;
    end

    // Output register; a combined write-and-update takes the new code
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) dac_q <= rst_val;
        else if (clr_hit)     dac_q <= clr_val;
        else if (upd)         dac_q <= wr_in ? wr_data : in_q;
        else if (load_copy)   dac_q <= in_q;
    end

    // Power mode, independent of the codes
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) pmode_q <= PM_NORMAL;
        else if (pd_set)      pmode_q <= pd_mode;
    end
endmodule

// File: rtl/dacq_ctrl.sv
// Top of the quad DAC register controller. Synchronises the load and clear
// pins, holds the clear code and override mask, and drives NCH channels.
// Assumes frame_word is stable while frame_valid is high for one cycle.
module dacq_ctrl
    import dacq_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned CW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_mid,
    input  logic              frame_valid,
    input  logic [31:0]       frame_word,
    input  logic              load_n,
    input  logic              clear_n,
    output logic [NCH*CW-1:0] dac_code,
    output logic [NCH*2-1:0]  pwr_mode
);
    localparam logic [CW-1:0] MID = {1'b1, {(CW-1){1'b0}}};

    logic           load_lvl, load_fall, clear_lvl, clear_fall;
    logic           frame_ok, clr_hit, clr_ld, mask_ld, sw_rst;
    clr_code_e      clr_code;
    logic [NCH-1:0] ovr_mask, wr_in, upd, pd_set;
    logic [CW-1:0]  rst_val, clr_val;

    dacq_pin_sync u_load_sync (
        .clk(clk), .rst_n(rst_n), .pin(load_n), .level(load_lvl), .fall(load_fall)
    );
    dacq_pin_sync u_clear_sync (
        .clk(clk), .rst_n(rst_n), .pin(clear_n), .level(clear_lvl), .fall(clear_fall)
    );

    // A clear edge aborts a frame arriving in the same cycle
    assign frame_ok = frame_valid && !clear_fall;
    assign clr_hit  = clear_fall && (clr_code != CC_NONE);
    assign rst_val  = rst_mid ? MID : '0;

    // Map the clear code to a register value
    always_comb begin
        case (clr_code)
            CC_MID:  clr_val = MID;
            CC_FULL: clr_val = '1;
            default: clr_val = '0;
        endcase
    end

    dacq_decode #(.NCH(NCH)) u_decode (
        .frame_ok(frame_ok), .word(frame_word), .load_low(!load_lvl),
        .ovr_mask(ovr_mask), .wr_in(wr_in), .upd(upd), .pd_set(pd_set),
        .clr_ld(clr_ld), .mask_ld(mask_ld), .sw_rst(sw_rst)
    );

    // Clear code and override mask registers
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            clr_code <= CC_ZERO;
            ovr_mask <= '0;
        end else begin
            if (clr_ld)  clr_code <= clr_code_e'(frame_word[1:0]);
            if (mask_ld) ovr_mask <= frame_word[NCH-1:0];
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pmode_e pm;
        dacq_channel #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .rst_val(rst_val),
            .clr_hit(clr_hit), .clr_val(clr_val),
            .wr_in(wr_in[i]), .wr_data(frame_word[CW+3:4]), .upd(upd[i]),
            .load_copy(load_fall && clear_lvl), .pd_set(pd_set[i]),
            .pd_mode(pmode_e'(frame_word[9:8])),
            .dac_q(dac_code[i*CW +: CW]), .pmode_q(pm)
        );
        assign pwr_mode[i*2 +: 2] = pm;
    end
endmodule

// File: rtl/dacq_ctrl_chk.sv
// Property checker for dacq_ctrl, attached by bind below.
module dacq_ctrl_chk
    import dacq_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned CW  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rst_mid,
    input logic              frame_valid,
    input logic [31:0]       frame_word,
    input logic [NCH*CW-1:0] dac_code,
    input logic [NCH*2-1:0]  pwr_mode,
    input logic              load_fall,
    input logic              clear_fall,
    input clr_code_e         clr_code
);
    localparam logic [CW-1:0] MID = {1'b1, {(CW-1){1'b0}}};

    logic quiet;
    assign quiet = !load_fall && !clear_fall;

    assert_reset_value_R1: assert property (@(posedge clk)
        !rst_n |=> dac_code == {NCH{($past(rst_mid) ? MID : {CW{1'b0}})}});

    assert_reserved_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && frame_word[27] && quiet |=> $stable(dac_code) && $stable(pwr_mode));

    assert_pd_keeps_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && frame_word[27:24] == OP_POWER && quiet |=> $stable(dac_code));

    assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_fall && clr_code == CC_ZERO |=> dac_code == '0);

    assert_pmode_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_valid && !clear_fall &&
          (frame_word[27:24] == OP_POWER || frame_word[27:24] == OP_SWRESET))
        |=> $stable(pwr_mode));
endmodule

bind dacq_ctrl dacq_ctrl_chk #(.NCH(NCH), .CW(CW)) u_chk (.*);

// File: tb/tb_dacq_ctrl.sv
module tb_dacq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_mid = 1'b0;
    logic        frame_valid = 1'b0;
    logic [31:0] frame_word = '0;
    logic        load_n = 1'b0;
    logic        clear_n = 1'b1;
    logic [63:0] dac_code;
    logic [7:0]  pwr_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dacq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .rst_mid(rst_mid), .frame_valid(frame_valid),
        .frame_word(frame_word), .load_n(load_n), .clear_n(clear_n),
        .dac_code(dac_code), .pwr_mode(pwr_mode)
    );

    function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] a,
                                       input logic [15:0] d, input logic [3:0] lo);
        return {4'hA, op, a, d, lo};
    endfunction

    function automatic logic [15:0] ch(input int i);
        return dac_code[i*16 +: 16];
    endfunction

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic send(input logic [3:0] op, input logic [3:0] a,
                        input logic [15:0] d, input logic [3:0] lo);
        @(negedge clk);
        frame_word  = mk(op, a, d, lo);
        frame_valid = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0;
    endtask

    task automatic set_pin_load(input logic v);
        @(negedge clk);
        load_n = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_pin_clear(input logic v);
        @(negedge clk);
        clear_n = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset(input logic mid);
        @(negedge clk);
        rst_mid = mid;
        rst_n   = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        for (int i = 0; i < 4; i++) chk("R1 zero", ch(i), 16'h0000);
        chk("R1 pmode", {8'h0, pwr_mode}, 16'h0000);
    endtask

    task automatic t_transparent();
        send(4'h0, 4'h0, 16'h1234, 4'hF);
        chk("R2 write ch0", ch(0), 16'h1234);
        chk("R2 ch1 untouched", ch(1), 16'h0000);
        send(4'h0, 4'h5, 16'h9999, 4'h0);
        for (int i = 0; i < 4; i++) chk("R7 bad address", ch(i), (i == 0) ? 16'h1234 : 16'h0000);
    endtask

    task automatic t_load_pin();
        set_pin_load(1'b1);
        send(4'h0, 4'h1, 16'hAAAA, 4'h0);
        chk("R3 held", ch(1), 16'h0000);
        @(negedge clk);
        load_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R3 not yet", ch(1), 16'h0000);
        @(negedge clk);
        chk("R3 copy on fall", ch(1), 16'hAAAA);
        chk("R3 ch0 kept", ch(0), 16'h1234);
        set_pin_load(1'b1);
    endtask

    task automatic t_commands();
        send(4'h0, 4'h2, 16'h5555, 4'h0);
        chk("R4 before copy", ch(2), 16'h0000);
        send(4'h1, 4'h2, 16'h0000, 4'h0);
        chk("R4 copy", ch(2), 16'h5555);
        send(4'h3, 4'h3, 16'h7777, 4'h0);
        chk("R6 write+update", ch(3), 16'h7777);
        send(4'h0, 4'h0, 16'h0101, 4'h0);
        send(4'h2, 4'h1, 16'h2222, 4'h0);
        chk("R5 ch0", ch(0), 16'h0101);
        chk("R5 ch1", ch(1), 16'h2222);
        send(4'h3, 4'hF, 16'h4444, 4'h0);
        for (int i = 0; i < 4; i++) chk("R7 all", ch(i), 16'h4444);
        send(4'h8, 4'hF, 16'h1111, 4'hF);
        send(4'hF, 4'h0, 16'h1111, 4'hF);
        send(4'hB, 4'h1, 16'h1111, 4'hF);
        for (int i = 0; i < 4; i++) chk("R8 reserved", ch(i), 16'h4444);
        chk("R8 pmode", {8'h0, pwr_mode}, 16'h0000);
    endtask

    task automatic t_override();
        send(4'h6, 4'h0, 16'h0000, 4'b0010);
        send(4'h0, 4'h1, 16'h6666, 4'h0);
        chk("R9 masked ch", ch(1), 16'h6666);
        send(4'h0, 4'h0, 16'h6767, 4'h0);
        chk("R9 unmasked ch", ch(0), 16'h4444);
        set_pin_load(1'b0);
        chk("R9 later load", ch(0), 16'h6767);
        set_pin_load(1'b1);
    endtask

    task automatic t_clear();
        send(4'h5, 4'h0, 16'h0000, 4'b0001);
        set_pin_clear(1'b0);
        for (int i = 0; i < 4; i++) chk("R10 mid", ch(i), 16'h8000);
        send(4'h1, 4'hF, 16'h0000, 4'h0);
        chk("R10 staging cleared", ch(1), 16'h8000);
        send(4'h0, 4'h2, 16'h3333, 4'h0);
        @(negedge clk);
        load_n = 1'b0;
        repeat (2) @(negedge clk);
        load_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11 load ignored", ch(2), 16'h8000);
        set_pin_clear(1'b1);
        send(4'h5, 4'h0, 16'h0000, 4'b0011);
        set_pin_clear(1'b0);
        chk("R10 code 11 idle", ch(2), 16'h8000);
        set_pin_clear(1'b1);
        send(4'h1, 4'h2, 16'h0000, 4'h0);
        chk("R10 code 11 staging kept", ch(2), 16'h3333);
        send(4'h5, 4'h0, 16'h0000, 4'b0010);
        @(negedge clk);
        clear_n = 1'b0;
        repeat (2) @(negedge clk);
        frame_word  = mk(4'h3, 4'h0, 16'h1357, 4'h0);
        frame_valid = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0;
        chk("R11 frame aborted", ch(0), 16'hFFFF);
        chk("R10 full", ch(3), 16'hFFFF);
        set_pin_clear(1'b1);
    endtask

    task automatic t_power();
        send(4'h4, 4'h7, 16'h0020, 4'b0101);
        chk("R12 modes", {8'h0, pwr_mode}, 16'h0022);
        chk("R12 code kept", ch(0), 16'hFFFF);
        send(4'h4, 4'h0, 16'h0030, 4'b1000);
        chk("R12 hiz", {8'h0, pwr_mode}, 16'h00E2);
        send(4'h4, 4'h0, 16'h0010, 4'b0010);
        chk("R12 1k", {8'h0, pwr_mode}, 16'h00E6);
    endtask

    task automatic t_swreset();
        @(negedge clk);
        rst_mid = 1'b1;
        send(4'h7, 4'h0, 16'h0000, 4'h0);
        for (int i = 0; i < 4; i++) chk("R13 mid", ch(i), 16'h8000);
        chk("R13 pmode", {8'h0, pwr_mode}, 16'h0000);
        send(4'h0, 4'h1, 16'h2468, 4'h0);
        chk("R13 mask cleared", ch(1), 16'h8000);
        set_pin_clear(1'b0);
        for (int i = 0; i < 4; i++) chk("R13 clear code zero", ch(i), 16'h0000);
        set_pin_clear(1'b1);
        do_reset(1'b1);
        for (int i = 0; i < 4; i++) chk("R1 mid", ch(i), 16'h8000);
    endtask

    initial begin
        t_reset();
        t_transparent();
        t_load_pin();
        t_commands();
        t_override();
        t_clear();
        t_power();
        t_swreset();
        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < 20000 && !done; n++) @(negedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule